// File: doc/BRIEF.md
# Dual cascadable pixel FIFO

This block holds pixel words between a memory fetch engine and a display pixel pipeline. The two sides run on unrelated clocks. Words are written on the bus clock and read on the pixel clock. Two storage queues of 16 entries by 64 bits sit inside. In split mode each queue feeds one half of a two-half panel, and a select line on each side picks the queue. In joined mode the two queues act as one 32-entry queue, and both select lines are ignored.

The fetch engine watches one request flag per queue. A flag is high while at least four entries are free. It uses the flags to decide when to start a burst. If the pixel side reads a queue that holds nothing, the block returns a zero word and raises a sticky underflow interrupt. The read pointer does not move on such a read.

Pointers cross between the clocks in gray code through two-stage synchronizers. Both the free space seen by the writer and the empty flag seen by the reader are therefore conservative. The mode input is static and changes only while both resets are held.

Top module: `dual_pixel_fifo`

## Requirements
- R1: After reset, `wr_req` is 2'b11 in split mode (2'b01 in joined mode), `rd_empty` is 2'b11, `irq_underflow` is 0 and `rd_data` is 0.
- R2: In split mode (`cascade`=0), `wr_sel`/`rd_sel` value 0 selects queue 0 and value 1 selects queue 1. Each queue returns its own words in the order written, whatever the traffic on the other queue.
- R3: In split mode each queue holds 16 words. A write to a queue that looks full on the write side is dropped, and the stored contents do not change.
- R4: In joined mode (`cascade`=1), the block holds 32 words, returns them oldest first, and ignores `wr_sel` and `rd_sel`.
- R5: `wr_req[i]` is high exactly when the write-side free count of queue i is at least 4. The capacity is 16 per queue in split mode and 32 for the joined queue. In joined mode `wr_req[1]` is held low.
- R6: A read of an empty queue returns an all-zero word and leaves the read pointer where it was, so the next word written is the next word read.
- R7: Every empty read sets `irq_underflow`. It stays set until a one-cycle pulse on `irq_clr`, and a new underflow in the same cycle as a clear wins.
- R8: `rd_data` changes one pixel clock after a cycle with `rd_en` high, and holds its value in every other cycle.
- R9: `rd_empty[i]` is high while queue i holds no word visible to the read side. It goes low only after a write has crossed the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Bus (write) clock |
| wrst_n | input | 1 | Active-low reset, write domain |
| cascade | input | 1 | 0 = split mode, 1 = joined 32-entry mode (static) |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Queue select for writes in split mode |
| wr_data | input | 64 | Pixel word to store |
| wr_req | output | 2 | Per-queue flag: at least 4 entries free |
| rclk | input | 1 | Pixel (read) clock |
| rrst_n | input | 1 | Active-low reset, read domain |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | Queue select for reads in split mode |
| rd_data | output | 64 | Registered read word, zero on underflow |
| rd_empty | output | 2 | Per-queue empty flag, read domain |
| irq_underflow | output | 1 | Sticky underflow interrupt |
| irq_clr | input | 1 | Clears the underflow interrupt |

## Verification
The hardest state to reach is the joined queue wrapping across its bank edge while full, with writes arriving that must be dropped. The write side only sees space freed by reads after the pointers have crossed the clock boundary. The stimulus alternates `wr_sel` and `rd_sel` so that any wrong use of a select line would show. It writes past capacity and waits for the synchronizers to settle before draining, so the drop decisions are unambiguous. It then reads one word more than was stored, which exercises underflow and the interrupt at the end of a full drain.

// File: rtl/dpf_pkg.sv
package dpf_pkg;
  typedef enum logic {
    MODE_SPLIT  = 1'b0,
    MODE_JOINED = 1'b1
  } fifo_mode_e;
endpackage

// File: rtl/dpf_sync.sv
module dpf_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dpf_chan.sv
module dpf_chan #(
  parameter int   AW   = 4,
  parameter int   PW   = AW + 2,
  parameter logic BANK = 1'b0
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          joined,
  input  logic [PW-1:0] cap,
  input  logic          push,
  input  logic          pop,
  output logic          push_ok,
  output logic [PW-1:0] wfree,
  output logic [AW:0]   waddr,
  output logic [AW:0]   raddr,
  output logic          rempty
);
  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [AW:0] slot_of(input logic [PW-1:0] p, input logic j);
    return j ? p[AW:0] : {BANK, p[AW-1:0]};
  endfunction

  logic [PW-1:0] wptr, rptr, wgray, rgray, wgray_s, rgray_s;
  logic [PW-1:0] rptr_w, wptr_r;
  logic          wfull, pop_ok;

  assign rptr_w  = gray2bin(rgray_s);
  assign wfree   = cap - (wptr - rptr_w);
  assign wfull   = (wfree == '0);
  assign push_ok = push & ~wfull;

  assign wptr_r  = gray2bin(wgray_s);
  assign rempty  = (wptr_r == rptr);
  assign pop_ok  = pop & ~rempty;

  assign waddr = slot_of(wptr, joined);
  assign raddr = slot_of(rptr, joined);

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wptr  <= '0;
      wgray <= '0;
    end else begin
      wptr  <= wptr + {{(PW-1){1'b0}}, push_ok};
      wgray <= bin2gray(wptr);
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rptr  <= '0;
      rgray <= '0;
    end else begin
      rptr  <= rptr + {{(PW-1){1'b0}}, pop_ok};
      rgray <= bin2gray(rptr);
    end
  end

  dpf_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));
  dpf_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));
endmodule

// File: rtl/dual_pixel_fifo.sv
module dual_pixel_fifo
  import dpf_pkg::*;
#(
  parameter int DW    = 64,
  parameter int DEPTH = 16,
  parameter int WM    = 4
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          cascade,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic [1:0]    wr_req,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_en,
  input  logic          rd_sel,
  output logic [DW-1:0] rd_data,
  output logic [1:0]    rd_empty,
  output logic          irq_underflow,
  input  logic          irq_clr
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 2;
  localparam logic [PW-1:0] CAP_ONE  = PW'(DEPTH);
  localparam logic [PW-1:0] CAP_BOTH = PW'(2 * DEPTH);
  localparam logic [PW-1:0] WM_LVL   = PW'(WM);

  fifo_mode_e mode;
  logic       joined;
  assign mode   = fifo_mode_e'(cascade);
  assign joined = (mode == MODE_JOINED);

  logic [1:0]          push_c, pop_c, push_ok_c, rempty_c;
  logic [1:0][PW-1:0]  wfree_c;
  logic [1:0][AW:0]    waddr_c, raddr_c;
  logic [PW-1:0]       cap0;

  assign cap0 = joined ? CAP_BOTH : CAP_ONE;

  // queue steering: joined mode always uses channel 0 pointers
  logic wch, rch;
  assign wch       = joined ? 1'b0 : wr_sel;
  assign rch       = joined ? 1'b0 : rd_sel;
  assign push_c[0] = wr_en & ~wch;
  assign push_c[1] = wr_en &  wch;
  assign pop_c[0]  = rd_en & ~rch;
  assign pop_c[1]  = rd_en &  rch;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    dpf_chan #(
      .AW  (AW),
      .PW  (PW),
      .BANK((c == 1) ? 1'b1 : 1'b0)
    ) u_chan (
      .wclk   (wclk),
      .wrst_n (wrst_n),
      .rclk   (rclk),
      .rrst_n (rrst_n),
      .joined (joined),
      .cap    ((c == 0) ? cap0 : CAP_ONE),
      .push   (push_c[c]),
      .pop    (pop_c[c]),
      .push_ok(push_ok_c[c]),
      .wfree  (wfree_c[c]),
      .waddr  (waddr_c[c]),
      .raddr  (raddr_c[c]),
      .rempty (rempty_c[c])
    );
  end

  assign wr_req[0] = (wfree_c[0] >= WM_LVL);
  assign wr_req[1] = (wfree_c[1] >= WM_LVL) & ~joined;
  assign rd_empty  = rempty_c;

  // shared storage: two banks of DEPTH words, flat index {bank, slot}
  logic [DW-1:0] mem [2*DEPTH];
  logic [AW:0]   wslot, rslot;
  logic          wfire, sel_empty, underflow_evt;

  assign wslot         = wch ? waddr_c[1] : waddr_c[0];
  assign rslot         = rch ? raddr_c[1] : raddr_c[0];
  assign wfire         = |push_ok_c;
  assign sel_empty     = rch ? rempty_c[1] : rempty_c[0];
  assign underflow_evt = rd_en & sel_empty;

  always_ff @(posedge wclk) begin
    if (wfire) mem[wslot] <= wr_data;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rd_data       <= '0;
      irq_underflow <= 1'b0;
    end else begin
      if (rd_en) rd_data <= sel_empty ? '0 : mem[rslot];
      irq_underflow <= underflow_evt | (irq_underflow & ~irq_clr);
    end
  end
endmodule

// File: rtl/dpf_check.sv
module dpf_check #(
  parameter int DW    = 64,
  parameter int DEPTH = 16,
  parameter int WM    = 4,
  parameter int PW    = $clog2(DEPTH) + 2
) (
  input logic          wclk,
  input logic          wrst_n,
  input logic          rclk,
  input logic          rrst_n,
  input logic          cascade,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic          irq_underflow,
  input logic          irq_clr,
  input logic [1:0]    wr_req,
  input logic [PW-1:0] wfree0,
  input logic [PW-1:0] wfree1,
  input logic          underflow_evt
);
  logic [PW-1:0] cap0;
  assign cap0 = cascade ? PW'(2 * DEPTH) : PW'(DEPTH);

  AST_UNDER_ZERO: assert property (@(posedge rclk) disable iff (!rrst_n)
    underflow_evt |=> (rd_data == '0));  // R6
  AST_UNDER_IRQ: assert property (@(posedge rclk) disable iff (!rrst_n)
    underflow_evt |=> irq_underflow);  // R7
  AST_IRQ_STICKY: assert property (@(posedge rclk) disable iff (!rrst_n)
    (irq_underflow && !irq_clr) |=> irq_underflow);  // R7
  AST_IRQ_CLEAR: assert property (@(posedge rclk) disable iff (!rrst_n)
    (irq_clr && !underflow_evt) |=> !irq_underflow);  // R7
  AST_DATA_HOLD: assert property (@(posedge rclk) disable iff (!rrst_n)
    !rd_en |=> $stable(rd_data));  // R8
  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wfree0 <= cap0) && (wfree1 <= PW'(DEPTH)));  // R3
  AST_JOINED_REQ_LOW: assert property (@(posedge wclk) disable iff (!wrst_n)
    cascade |-> !wr_req[1]);  // R5
endmodule

bind dual_pixel_fifo dpf_check #(.DW(DW), .DEPTH(DEPTH), .WM(WM)) u_chk (
  .wclk         (wclk),
  .wrst_n       (wrst_n),
  .rclk         (rclk),
  .rrst_n       (rrst_n),
  .cascade      (cascade),
  .rd_en        (rd_en),
  .rd_data      (rd_data),
  .irq_underflow(irq_underflow),
  .irq_clr      (irq_clr),
  .wr_req       (wr_req),
  .wfree0       (wfree_c[0]),
  .wfree1       (wfree_c[1]),
  .underflow_evt(underflow_evt)
);

// File: tb/dual_pixel_fifo_test.sv
module dual_pixel_fifo_test;
  logic        wclk = 1'b0, rclk = 1'b0;
  logic        wrst_n = 1'b0, rrst_n = 1'b0;
  logic        cascade = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [63:0] wr_data = '0;
  logic [1:0]  wr_req;
  logic        rd_en = 1'b0, rd_sel = 1'b0;
  logic [63:0] rd_data;
  logic [1:0]  rd_empty;
  logic        irq_underflow;
  logic        irq_clr = 1'b0;

  int checks = 0, errors = 0;
  logic [63:0] q0[$], q1[$];
  int cap0 = 16;

  always #5 wclk = ~wclk;
  always #7 rclk = ~rclk;

  dual_pixel_fifo uut (
    .wclk(wclk), .wrst_n(wrst_n), .cascade(cascade), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .wr_req(wr_req),
    .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_data(rd_data), .rd_empty(rd_empty), .irq_underflow(irq_underflow),
    .irq_clr(irq_clr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic joined);
    @(negedge wclk);
    wrst_n = 1'b0; rrst_n = 1'b0; cascade = joined;
    q0.delete(); q1.delete();
    cap0 = joined ? 32 : 16;
    repeat (3) @(negedge rclk);
    wrst_n = 1'b1; rrst_n = 1'b1;
    repeat (2) @(negedge wclk);
  endtask

  // driver: pushes the word and records what the bench expects to come out
  task automatic push_word(input logic sel, input logic [63:0] d);
    @(negedge wclk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge wclk);
    wr_en = 1'b0;
    if (cascade || !sel) begin
      if (q0.size() < cap0) q0.push_back(d);
    end else begin
      if (q1.size() < 16) q1.push_back(d);
    end
  endtask

  // monitor side: one read, compare against the scoreboard head
  task automatic pop_word(input logic sel, input string req);
    logic [63:0] exp;
    logic        und;
    @(negedge rclk);
    rd_en = 1'b1; rd_sel = sel;
    @(negedge rclk);
    rd_en = 1'b0;
    und = 1'b0;
    if (cascade || !sel) begin
      if (q0.size() > 0) exp = q0.pop_front(); else begin exp = '0; und = 1'b1; end
    end else begin
      if (q1.size() > 0) exp = q1.pop_front(); else begin exp = '0; und = 1'b1; end
    end
    chk(und ? "R6" : req, rd_data, exp);
    if (und) chk("R7", {63'b0, irq_underflow}, 64'd1);
  endtask

  task automatic clear_irq();
    @(negedge rclk); irq_clr = 1'b1;
    @(negedge rclk); irq_clr = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
    repeat (8) @(negedge wclk);
  endtask

  task automatic run_all();
    logic [63:0] held;
    // ---- split mode ----
    do_reset(1'b0);
    chk("R1", {62'b0, wr_req}, 64'd3);
    chk("R1", {62'b0, rd_empty}, 64'd3);
    chk("R1", {63'b0, irq_underflow}, 64'd0);
    chk("R1", rd_data, 64'd0);
    for (int i = 0; i < 12; i++) push_word(1'b0, 64'h1000 + 64'(i));
    chk("R5", {63'b0, wr_req[0]}, 64'd1);
    push_word(1'b0, 64'h100c);
    chk("R5", {62'b0, wr_req}, 64'd2);
    for (int i = 13; i < 18; i++) push_word(1'b0, 64'h1000 + 64'(i));  // R3: last two dropped
    chk("R3", {63'b0, wr_req[0]}, 64'd0);
    for (int i = 0; i < 3; i++) push_word(1'b1, 64'h2000 + 64'(i));
    settle();
    chk("R9", {62'b0, rd_empty}, 64'd0);
    for (int i = 0; i < 3; i++) pop_word(1'b1, "R2");
    held = rd_data;
    repeat (4) @(negedge rclk);
    chk("R8", rd_data, held);
    repeat (4) @(negedge rclk);
    chk("R9", {63'b0, rd_empty[1]}, 64'd1);
    pop_word(1'b1, "R6");
    repeat (3) @(negedge rclk);
    chk("R7", {63'b0, irq_underflow}, 64'd1);
    clear_irq();
    chk("R7", {63'b0, irq_underflow}, 64'd0);
    push_word(1'b1, 64'h2abc);  // R6: pointer must not have moved
    settle();
    pop_word(1'b1, "R6");
    for (int i = 0; i < 16; i++) pop_word(1'b0, "R3");
    pop_word(1'b0, "R6");
    clear_irq();
    settle();
    chk("R5", {62'b0, wr_req}, 64'd3);
    // ---- joined mode ----
    do_reset(1'b1);
    chk("R1", {62'b0, wr_req}, 64'd1);
    for (int i = 0; i < 28; i++) push_word(i[0], 64'h3000 + 64'(i));
    chk("R5", {62'b0, wr_req}, 64'd1);
    push_word(1'b1, 64'h301c);
    chk("R5", {62'b0, wr_req}, 64'd0);
    for (int i = 29; i < 34; i++) push_word(i[0], 64'h3000 + 64'(i));
    settle();
    chk("R9", {63'b0, rd_empty[0]}, 64'd0);
    for (int i = 0; i < 32; i++) pop_word(~i[0], "R4");
    pop_word(1'b1, "R6");
    settle();
    chk("R5", {62'b0, wr_req}, 64'd1);
  endtask

  initial begin
    fork
      run_all();
      begin
        #3ms;
        errors++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule